// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block sits on the master side of an asynchronous bus and owns the life of one bus cycle. A start pulse asserts the active-low address strobe. The controller then watches three active-low responder inputs: acknowledge, bus error and halt. It decides how the cycle ended from the order in which those inputs appear. There are four outcomes: normal, halt, bus error and retry. A bus error or halt that shows up one sample after acknowledge still counts. The decision comes out as a one-clock end-of-cycle pulse, together with a 2-bit termination code, an exception request and a retry request.

A built-in bus monitor counts clocks while the strobe is asserted. If no response has come within a programmable window, it acts as if bus error had been asserted. Retried cycles are reissued automatically once the responder has released all three inputs. The number of retries in a row is capped, and a retry beyond the cap is reported as a bus error. Each responder input passes through its own flop synchroniser before it is used.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset the strobe `as_no` is high and `done_o`, `exc_req_o` and `retry_req_o` are low.
- R2: In the idle state a `start_i` pulse asserts `as_no` low on the next clock. A start that arrives while a cycle or its recovery is in progress is dropped and is not queued.
- R3: With acknowledge alone the cycle ends with code 2'b00. `done_o` rises four clocks after acknowledge is driven: two synchroniser stages, one decision and one late-watch clock. Neither request output is raised.
- R4: Halt sampled with or before acknowledge, with bus error absent, gives code 2'b01. No new cycle can start until acknowledge, bus error and halt are all released.
- R5: Bus error sampled before, with, or instead of acknowledge gives code 2'b10 if halt has not been sampled by then. `exc_req_o` pulses together with `done_o`.
- R6: Bus error sampled exactly one clock after acknowledge gives code 2'b10. Bus error arriving two or more clocks after acknowledge is ignored and gives code 2'b00. Halt arriving only after acknowledge, without bus error, also gives code 2'b00.
- R7: Bus error and halt both sampled, in any order, with halt no later than bus error and bus error no later than one clock after acknowledge, give code 2'b11 with `retry_req_o` high. The same cycle is reissued with `as_no` low once all three inputs are released.
- R8: At most RETRY_MAX retries are reported in a row. A retry outcome beyond that count is reported as code 2'b10 with `exc_req_o`, and the cycle is not reissued.
- R9: With `tmo_en_i` high and no response, `done_o` rises exactly (`tmo_sel_i`+1)*16 clocks after `as_no` falls. The code is 2'b10, or 2'b11 if halt was sampled. With `tmo_en_i` low, the cycle waits without limit.
- R10: `done_o` is a one-clock pulse and `as_no` is already high while it is asserted. The strobe is negated only when the code is committed. A termination input held over from the previous cycle cannot end a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a bus cycle |
| ack_ni | input | 1 | Acknowledge from responder, active low, asynchronous |
| berr_ni | input | 1 | Bus error from responder, active low, asynchronous |
| halt_ni | input | 1 | Halt from responder, active low, asynchronous |
| tmo_en_i | input | 1 | Enables the bus monitor |
| tmo_sel_i | input | TMO_W | Monitor window select; window is (value+1)*TMO_STEP clocks |
| as_no | output | 1 | Address strobe, active low |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| code_o | output | 2 | Termination code: 00 normal, 01 halt, 10 bus error, 11 retry |
| exc_req_o | output | 1 | Exception request, pulses with a bus error outcome |
| retry_req_o | output | 1 | Retry request, pulses with a retry outcome |

## Verification
Two functions can coincide. Acknowledge and bus error may land in the same sample, and the late-watch clock after acknowledge may catch the first bus error sample. The monitor timeout may also coincide with a halt that is already sampled, which turns a forced bus error into a retry. The bench provokes these with directed offsets of zero and one clock between the inputs, a halted timeout, and random offsets around those same points. Each outcome is judged by a bench function that derives the code from the offsets and tracks the retry streak.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

    typedef enum logic [1:0] {
        TC_NORMAL = 2'b00,
        TC_HALT   = 2'b01,
        TC_BERR   = 2'b10,
        TC_RETRY  = 2'b11
    } term_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LATE,
        ST_COMMIT,
        ST_DRAIN
    } bus_state_e;

    // Synchronised responder inputs, active high
    typedef struct packed {
        logic ack;
        logic berr;
        logic halt;
    } term_in_t;

    function automatic term_code_e classify(input logic err, input logic hlt);
        if (err) return hlt ? TC_RETRY : TC_BERR;
        return hlt ? TC_HALT : TC_NORMAL;
    endfunction

endpackage

// File: rtl/term_sync.sv
module term_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] act
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else if (s == 0) chain[s] <= raw_n;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign act = ~chain[STAGES-1];
endmodule

// File: rtl/term_timer.sv
module term_timer #(
    parameter int TMO_W    = 4,
    parameter int TMO_STEP = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             en,
    input  logic [TMO_W-1:0] sel,
    output logic             expire
);
    localparam int CNT_W = TMO_W + $clog2(TMO_STEP) + 1;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] STEPV = CNT_W'(TMO_STEP);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim    = (CNT_W'(sel) + ONE) * STEPV;
    assign expire = en && run && (cnt == lim - ONE);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + ONE;
    end
endmodule

// File: rtl/term_fsm.sv
module term_fsm
    import bus_term_pkg::*;
#(
    parameter int RETRY_W   = 2,
    parameter int RETRY_MAX = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  term_in_t   tin,
    input  logic       expire,
    output logic       run,
    output logic       as_n,
    output logic       done,
    output term_code_e code,
    output logic       exc_req,
    output logic       retry_req
);
    localparam logic [RETRY_W-1:0] RMAX = RETRY_W'(RETRY_MAX);
    localparam logic [RETRY_W-1:0] RONE = RETRY_W'(1);

    bus_state_e         state, nxt;
    term_code_e         code_q, nxt_code, raw, fin;
    logic [RETRY_W-1:0] rcnt, nxt_r;
    logic               hk, nxt_hk;
    logic               decide;

    always_comb begin
        nxt      = state;
        nxt_code = code_q;
        nxt_r    = rcnt;
        nxt_hk   = hk;
        raw      = TC_NORMAL;
        decide   = 1'b0;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_WAIT;
            ST_WAIT: begin
                if (tin.berr || expire) begin
                    raw    = classify(1'b1, tin.halt);
                    decide = 1'b1;
                end else if (tin.ack) begin
                    nxt    = ST_LATE;
                    nxt_hk = tin.halt;
                end
            end
            ST_LATE: begin
                raw    = classify(tin.berr, tin.berr ? (hk | tin.halt) : hk);
                decide = 1'b1;
            end
            ST_COMMIT: nxt = ST_DRAIN;
            ST_DRAIN: begin
                if (!tin.ack && !tin.berr && !tin.halt)
                    nxt = (code_q == TC_RETRY) ? ST_WAIT : ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        fin = (raw == TC_RETRY && rcnt >= RMAX) ? TC_BERR : raw;
        if (decide) begin
            nxt      = ST_COMMIT;
            nxt_code = fin;
            nxt_r    = (fin == TC_RETRY) ? rcnt + RONE : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            code_q <= TC_NORMAL;
            rcnt   <= '0;
            hk     <= 1'b0;
        end else begin
            state  <= nxt;
            code_q <= nxt_code;
            rcnt   <= nxt_r;
            hk     <= nxt_hk;
        end
    end

    assign run       = (state == ST_WAIT);
    assign as_n      = !(state == ST_WAIT || state == ST_LATE);
    assign done      = (state == ST_COMMIT);
    assign code      = code_q;
    assign exc_req   = done && (code_q == TC_BERR);
    assign retry_req = done && (code_q == TC_RETRY);
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
    import bus_term_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 4,
    parameter int TMO_STEP    = 16,
    parameter int RETRY_W     = 2,
    parameter int RETRY_MAX   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             ack_ni,
    input  logic             berr_ni,
    input  logic             halt_ni,
    input  logic             tmo_en_i,
    input  logic [TMO_W-1:0] tmo_sel_i,
    output logic             as_no,
    output logic             done_o,
    output logic [1:0]       code_o,
    output logic             exc_req_o,
    output logic             retry_req_o
);
    localparam int NIN = 3;

    logic [NIN-1:0] act;
    term_in_t       tin;
    logic           run, expire;
    term_code_e     code;

    term_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_n ({ack_ni, berr_ni, halt_ni}),
        .act   (act)
    );

    assign tin = term_in_t'(act);

    term_timer #(.TMO_W(TMO_W), .TMO_STEP(TMO_STEP)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .en     (tmo_en_i),
        .sel    (tmo_sel_i),
        .expire (expire)
    );

    term_fsm #(.RETRY_W(RETRY_W), .RETRY_MAX(RETRY_MAX)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .tin       (tin),
        .expire    (expire),
        .run       (run),
        .as_n      (as_no),
        .done      (done_o),
        .code      (code),
        .exc_req   (exc_req_o),
        .retry_req (retry_req_o)
    );

    assign code_o = code;
endmodule

// File: rtl/bus_term_ctrl_chk.sv
module bus_term_ctrl_chk #(
    parameter int TMO_W     = 4,
    parameter int TMO_STEP  = 16,
    parameter int RETRY_MAX = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       tmo_en_i,
    input logic       as_no,
    input logic       done_o,
    input logic [1:0] code_o,
    input logic       exc_req_o,
    input logic       retry_req_o
);
    localparam int MAXLIM = (2**TMO_W) * TMO_STEP;

    logic [19:0] low_cnt;
    logic [7:0]  streak;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            streak  <= '0;
        end else begin
            low_cnt <= as_no ? '0 : ((low_cnt == 20'hFFFFF) ? low_cnt : low_cnt + 20'd1);
            if (retry_req_o)  streak <= streak + 8'd1;
            else if (done_o)  streak <= '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (as_no && !done_o && !exc_req_o && !retry_req_o)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R10
    AST_STROBE_OFF_AT_DONE: assert property (@(posedge clk) disable iff (rst) done_o |-> as_no); // R10
    AST_STROBE_RISE_COMMIT: assert property (@(posedge clk) disable iff (rst) $rose(as_no) |-> done_o); // R10
    AST_EXC_IS_BERR: assert property (@(posedge clk) disable iff (rst) exc_req_o |-> (done_o && code_o == 2'b10)); // R5
    AST_RETRY_IS_CODE: assert property (@(posedge clk) disable iff (rst) retry_req_o |-> (done_o && code_o == 2'b11)); // R7
    AST_RETRY_CAP: assert property (@(posedge clk) disable iff (rst) 32'(streak) <= RETRY_MAX); // R8
    AST_MONITOR_BOUND: assert property (@(posedge clk) disable iff (rst) (tmo_en_i && !as_no) |-> (32'(low_cnt) <= MAXLIM + 1)); // R9
endmodule

bind bus_term_ctrl bus_term_ctrl_chk #(
    .TMO_W(TMO_W), .TMO_STEP(TMO_STEP), .RETRY_MAX(RETRY_MAX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tmo_en_i    (tmo_en_i),
    .as_no       (as_no),
    .done_o      (done_o),
    .code_o      (code_o),
    .exc_req_o   (exc_req_o),
    .retry_req_o (retry_req_o)
);

// File: tb/bus_term_ctrl_bench.sv
module bus_term_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RMAX       = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       ack_ni = 1'b1, berr_ni = 1'b1, halt_ni = 1'b1;
    logic       tmo_en_i = 1'b1;
    logic [3:0] tmo_sel_i = 4'd15;
    logic       as_no, done_o, exc_req_o, retry_req_o;
    logic [1:0] code_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rc     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_term_ctrl #(.RETRY_MAX(RMAX)) u_bus_term_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i),
        .ack_ni(ack_ni), .berr_ni(berr_ni), .halt_ni(halt_ni),
        .tmo_en_i(tmo_en_i), .tmo_sel_i(tmo_sel_i),
        .as_no(as_no), .done_o(done_o), .code_o(code_o),
        .exc_req_o(exc_req_o), .retry_req_o(retry_req_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung act=%0d exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Raw outcome from offsets (clocks after strobe seen low, -1 = never)
    function automatic int exp_raw(input int a, input int b, input int h);
        if (b >= 0 && (a < 0 || b <= a + 1))
            return (h >= 0 && h <= b) ? 3 : 2;
        return (h >= 0 && h <= a) ? 1 : 0;
    endfunction

    // Applies the retry cap and updates the streak model
    function automatic int apply_cap(input int raw);
        if (raw == 3 && rc < RMAX) begin
            rc++;
            return 3;
        end
        rc = 0;
        return (raw == 3) ? 2 : raw;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic release_all();
        ack_ni = 1'b1; berr_ni = 1'b1; halt_ni = 1'b1;
    endtask

    task automatic run_cycle(input int a, input int b, input int h, input bit keep,
                             input int exp, input int exp_k, input string req);
        int k;
        int guard;
        guard = 0;
        while (as_no && guard < 50) begin
            @(negedge clk); guard++;
        end
        chk({req, " strobe asserted"}, int'(as_no), 0);
        k = 0;
        while (!done_o && k < 700) begin
            if (k == a) ack_ni  = 1'b0;
            if (k == b) berr_ni = 1'b0;
            if (k == h) halt_ni = 1'b0;
            @(negedge clk); k++;
        end
        chk({req, " done seen"}, int'(done_o), 1);
        chk({req, " code"}, int'(code_o), exp);
        chk({req, " exc_req"}, int'(exc_req_o), int'(exp == 2));
        chk({req, " retry_req"}, int'(retry_req_o), int'(exp == 3));
        chk({req, " R10 strobe off at done"}, int'(as_no), 1);
        if (exp_k >= 0) chk({req, " latency"}, k, exp_k);
        if (!keep) release_all();
        @(negedge clk);
        chk({req, " R10 done one clock"}, int'(done_o), 0);
        if (!keep) repeat (4) @(negedge clk);
    endtask

    initial begin
        int a, b, h, e;
        void'($urandom(32'd4141));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobe", int'(as_no), 1);
        chk("R1 done", int'(done_o), 0);
        chk("R1 exc", int'(exc_req_o), 0);
        chk("R1 retry", int'(retry_req_o), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 / R3 normal with exact latency
        pulse_start();
        run_cycle(2, -1, -1, 0, 0, 6, "R2 R3 normal");
        // R3 ack immediately
        pulse_start();
        run_cycle(0, -1, -1, 0, 0, 4, "R3 normal fast");
        // R5 berr instead of ack, with ack, before ack
        pulse_start(); run_cycle(-1, 1, -1, 0, 2, 4, "R5 berr only");
        pulse_start(); run_cycle(3, 3, -1, 0, 2, -1, "R5 berr with ack");
        pulse_start(); run_cycle(4, 1, -1, 0, 2, -1, "R5 berr before ack");
        // R6 late cases
        pulse_start(); run_cycle(2, 3, -1, 0, 2, -1, "R6 berr one late");
        pulse_start(); run_cycle(2, 4, -1, 0, 0, -1, "R6 berr too late");
        pulse_start(); run_cycle(2, -1, 3, 0, 0, -1, "R6 halt after ack");

        // R4 halt termination, start dropped while halt held
        pulse_start(); run_cycle(3, -1, 1, 1, 1, -1, "R4 halt");
        ack_ni = 1'b1;
        repeat (6) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R2 R4 start ignored while halted", int'(as_no), 1);
        halt_ni = 1'b1;
        repeat (8) @(negedge clk);
        chk("R2 dropped start not queued", int'(as_no), 1);

        // R10 stale acknowledge does not end the next cycle
        pulse_start(); run_cycle(1, -1, -1, 1, 0, -1, "R10 first");
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R10 start held off by stale ack", int'(as_no), 1);
        release_all();
        repeat (5) @(negedge clk);
        pulse_start(); run_cycle(3, -1, -1, 0, 0, 7, "R10 fresh cycle");

        // R7 / R8 retry streak and cap
        pulse_start();
        rc = 0;
        for (int i = 0; i <= RMAX; i++) begin
            e = apply_cap(3);
            run_cycle(2, 2, 1, 0, e, -1, (i < RMAX) ? "R7 retry reissued" : "R8 retry cap");
        end
        repeat (4) @(negedge clk);
        chk("R8 no reissue after cap", int'(as_no), 1);
        // R7 retry with both after ack
        pulse_start(); e = apply_cap(3);
        run_cycle(1, 2, 2, 0, e, -1, "R7 retry late");
        // second cycle from reissue, normal clears streak
        e = apply_cap(0);
        run_cycle(1, -1, -1, 0, e, -1, "R7 reissue then normal");

        // R9 timeout
        tmo_sel_i = 4'd0;
        pulse_start(); run_cycle(-1, -1, -1, 0, 2, 16, "R9 timeout 16");
        tmo_sel_i = 4'd2;
        pulse_start(); run_cycle(-1, -1, -1, 0, 2, 48, "R9 timeout 48");
        tmo_sel_i = 4'd0;
        rc = 0;
        pulse_start(); e = apply_cap(3);
        run_cycle(-1, -1, 0, 0, e, 16, "R9 timeout with halt");
        e = apply_cap(0);
        run_cycle(0, -1, -1, 0, e, -1, "R9 reissue after timeout retry");
        // R9 disabled monitor
        tmo_en_i = 1'b0;
        pulse_start();
        while (as_no) @(negedge clk);
        begin
            int seen;
            seen = 0;
            repeat (300) begin
                @(negedge clk);
                if (done_o) seen = 1;
            end
            chk("R9 disabled monitor waits", seen, 0);
        end
        run_cycle(0, -1, -1, 0, 0, 4, "R9 disabled then ack");
        tmo_en_i  = 1'b1;
        tmo_sel_i = 4'd15;

        // Random mix around the coincidence points
        rc = 0;
        for (int n = 0; n < 60; n++) begin
            bit reissue;
            reissue = (n > 0) && (e == 3);
            b = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, 6));
            a = (b >= 0 && $urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, 5));
            h = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 6));
            e = apply_cap(exp_raw(a, b, h));
            if (!reissue) pulse_start();
            run_cycle(a, b, h, 0, e, -1, "R3 R5 R6 R7 R8 random");
        end
        if (e == 3) begin
            e = apply_cap(0);
            run_cycle(0, -1, -1, 0, e, -1, "R7 final reissue");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule